// File: doc/BRIEF.md
# PHY Discovery and Link Monitor

This sequencer brings up an Ethernet PHY with no help from software. After a start pulse it sweeps the management addresses and reads the first identifier register at each one. It stops at the first address that answers, then reads the second identifier register and reports the address and the full 32-bit identifier. A PHY that is still coming out of reset may miss the first sweep. To give it time, the sweep is repeated a fixed number of times, with a programmable wait between sweeps.

Once a PHY is found, the block polls it. Each polling iteration reads the basic control register, then the basic status register. The autonegotiation-enable bit in the control value decides which status bits must all be set before the link counts as ready. The block ends in one of three ways: link up, link timeout after a bounded number of iterations, or PHY not found. Each ending gives a single done pulse. The raw control and status words are captured for downstream decoding.

Register transfers go through a simple request/response port to an external management-bus serialiser. That serialiser is not part of this block.

Top module: `phy_link_seq`

## Requirements
- R1: Identifier-1 reads (management register 2) go to addresses in ascending order, starting at 0 in every sweep, and the sweep stops at the first address whose identifier-1 value is not 16'hFFFF.
- R2: For the PHY found, management register 3 is read next; `phy_id` reports {register 2 value, register 3 value}, `phy_addr` reports its address and `phy_found` is 1.
- R3: At most PASSES sweeps are made; before every sweep after the first, no request is issued for at least WAIT_CYCLES clock cycles.
- R4: If no address answers in any sweep, `not_found` is set, `phy_addr` reads 31, and neither register 0 nor register 1 is read.
- R5: When bit 12 of the control value (register 0) is 1, the link is ready only when status bits 5 and 2 (register 1) are both 1.
- R6: When bit 12 of the control value is 0, status bit 2 alone makes the link ready, whatever bit 5 holds.
- R7: Each polling iteration reads register 0, then register 1; after MAX_POLLS iterations without a ready link, `link_timeout` is set and `link_up` stays 0.
- R8: Each run ends with exactly one one-cycle `done` pulse, and at that point exactly one of `link_up`, `link_timeout` and `not_found` is 1; `busy` is high from the cycle after start until done.
- R9: Results (`phy_addr`, `phy_id`, `ctrl_reg`, `status_reg` and the flags) hold their values until the next accepted start, and a start pulse while busy is ignored.
- R10: `mdio_req` stays high with stable address and register until `mdio_rsp_valid` is seen, and then it drops; only one request is outstanding at a time.
- R11: After reset, `busy`, `done`, `mdio_req` and all result flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that starts discovery |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when the sequence ends |
| phy_found | output | 1 | A PHY answered the sweep |
| not_found | output | 1 | All sweeps ended without an answer |
| link_up | output | 1 | Required status bits were seen |
| link_timeout | output | 1 | Polling limit reached without link |
| phy_addr | output | 5 | Address of the PHY found (31 when none) |
| phy_id | output | 32 | {identifier-1, identifier-2} |
| ctrl_reg | output | 16 | Last control value read |
| status_reg | output | 16 | Last status value read |
| mdio_req | output | 1 | Read request to the serialiser |
| mdio_phy | output | 5 | PHY address of the request |
| mdio_reg | output | 5 | Register number of the request |
| mdio_rsp_valid | input | 1 | One-cycle pulse: read data valid |
| mdio_rdata | input | 16 | Read data |

## Verification
The bench places PHYs at several addresses and checks three corner cases of the sweep.
- With two PHYs present, the lower address must win. A design that kept scanning, or that restarted on a stray start pulse, would issue extra identifier reads.
- A PHY at address 31 tests the wrap boundary of the address counter.
- A PHY that wakes only during the third sweep shows that the inter-sweep wait happens; a design that skipped it would show no long request-free gaps.

The polling tests cover both link-criterion selections. A status word with only the link bit set must not satisfy an autonegotiating PHY. A word with only the autonegotiation-complete bit set must not satisfy a fixed-mode PHY. A design that swapped or merged the masks would finish one iteration early or late. The timeout case counts status reads exactly, so an off-by-one in the iteration limit shows up at once.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

  localparam int MGMT_ADDR_W = 5;

  localparam logic [4:0] REG_CTRL = 5'd0;
  localparam logic [4:0] REG_STAT = 5'd1;
  localparam logic [4:0] REG_ID1  = 5'd2;
  localparam logic [4:0] REG_ID2  = 5'd3;

  localparam int AN_ENABLE_BIT = 12;
  localparam int AN_DONE_BIT   = 5;
  localparam int LINK_OK_BIT   = 2;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WAIT,
    S_ID1,
    S_ID2,
    S_CTRL,
    S_STAT
  } seq_state_t;

  // Status bits that must all be set, chosen from the control word.
  function automatic logic [15:0] link_mask(input logic [15:0] ctrl);
    logic [15:0] m;
    m = '0;
    m[LINK_OK_BIT] = 1'b1;
    if (ctrl[AN_ENABLE_BIT]) m[AN_DONE_BIT] = 1'b1;
    return m;
  endfunction

  function automatic logic link_met(input logic [15:0] status, input logic [15:0] mask);
    return (status & mask) == mask;
  endfunction

  function automatic logic id_absent(input logic [15:0] id1);
    return id1 == 16'hFFFF;
  endfunction

  function automatic logic [4:0] reg_for_state(input seq_state_t s);
    case (s)
      S_ID1:   return REG_ID1;
      S_ID2:   return REG_ID2;
      S_CTRL:  return REG_CTRL;
      S_STAT:  return REG_STAT;
      default: return REG_ID1;
    endcase
  endfunction

endpackage

// File: rtl/phy_wait_timer.sv
module phy_wait_timer #(
  parameter int WAIT_CYCLES = 2_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic expired
);
  localparam int CNT_W = $clog2(WAIT_CYCLES + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (go) begin
      cnt <= CNT_W'(WAIT_CYCLES);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == CNT_W'(1));
endmodule

// File: rtl/phy_mdio_port.sv
module phy_mdio_port (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic [4:0]  phy_in,
  input  logic [4:0]  reg_in,
  output logic        mdio_req,
  output logic [4:0]  mdio_phy,
  output logic [4:0]  mdio_reg,
  input  logic        mdio_rsp_valid,
  input  logic [15:0] mdio_rdata,
  output logic        rd_done,
  output logic [15:0] rd_data
);
  logic accept;
  assign accept = mdio_req && mdio_rsp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdio_req <= 1'b0;
      mdio_phy <= '0;
      mdio_reg <= '0;
      rd_done  <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_done <= accept;
      if (accept) rd_data <= mdio_rdata;
      if (go) begin
        mdio_req <= 1'b1;
        mdio_phy <= phy_in;
        mdio_reg <= reg_in;
      end else if (accept) begin
        mdio_req <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/phy_link_seq.sv
module phy_link_seq
  import phy_seq_pkg::*;
#(
  parameter int PASSES      = 11,
  parameter int WAIT_CYCLES = 2_500_000,
  parameter int MAX_POLLS   = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic        busy,
  output logic        done,
  output logic        phy_found,
  output logic        not_found,
  output logic        link_up,
  output logic        link_timeout,
  output logic [4:0]  phy_addr,
  output logic [31:0] phy_id,
  output logic [15:0] ctrl_reg,
  output logic [15:0] status_reg,
  output logic        mdio_req,
  output logic [4:0]  mdio_phy,
  output logic [4:0]  mdio_reg,
  input  logic        mdio_rsp_valid,
  input  logic [15:0] mdio_rdata
);
  localparam int PASS_W = $clog2(PASSES + 1);
  localparam int POLL_W = $clog2(MAX_POLLS + 1);

  seq_state_t               state;
  logic [MGMT_ADDR_W-1:0]   addr_q;
  logic [PASS_W-1:0]        pass_q;
  logic [POLL_W-1:0]        poll_q;
  logic [15:0]              mask_q;
  logic                     go_q;
  logic                     tmr_go_q;
  logic                     rd_done;
  logic [15:0]              rd_data;
  logic                     tmr_exp;

  // Named internal events
  logic waiting, scan_miss, addr_last, pass_last, link_ok, poll_last;
  assign waiting   = (state == S_WAIT);
  assign scan_miss = rd_done && (state == S_ID1) && id_absent(rd_data);
  assign addr_last = (addr_q == '1);
  assign pass_last = (pass_q == PASS_W'(PASSES));
  assign link_ok   = link_met(rd_data, mask_q);
  assign poll_last = (poll_q == POLL_W'(MAX_POLLS - 1));

  assign busy     = (state != S_IDLE);
  assign phy_addr = addr_q;

  phy_mdio_port u_port (
    .clk            (clk),
    .rst_n          (rst_n),
    .go             (go_q),
    .phy_in         (addr_q),
    .reg_in         (reg_for_state(state)),
    .mdio_req       (mdio_req),
    .mdio_phy       (mdio_phy),
    .mdio_reg       (mdio_reg),
    .mdio_rsp_valid (mdio_rsp_valid),
    .mdio_rdata     (mdio_rdata),
    .rd_done        (rd_done),
    .rd_data        (rd_data)
  );

  phy_wait_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (tmr_go_q),
    .expired (tmr_exp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      addr_q       <= '0;
      pass_q       <= '0;
      poll_q       <= '0;
      mask_q       <= '0;
      go_q         <= 1'b0;
      tmr_go_q     <= 1'b0;
      done         <= 1'b0;
      phy_found    <= 1'b0;
      not_found    <= 1'b0;
      link_up      <= 1'b0;
      link_timeout <= 1'b0;
      phy_id       <= '0;
      ctrl_reg     <= '0;
      status_reg   <= '0;
    end else begin
      go_q     <= 1'b0;
      tmr_go_q <= 1'b0;
      done     <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          phy_found    <= 1'b0;
          not_found    <= 1'b0;
          link_up      <= 1'b0;
          link_timeout <= 1'b0;
          phy_id       <= '0;
          ctrl_reg     <= '0;
          status_reg   <= '0;
          addr_q       <= '0;
          pass_q       <= PASS_W'(1);
          go_q         <= 1'b1;
          state        <= S_ID1;
        end
        S_WAIT: if (tmr_exp) begin
          go_q  <= 1'b1;
          state <= S_ID1;
        end
        S_ID1: if (rd_done) begin
          if (scan_miss) begin
            if (!addr_last) begin
              addr_q <= addr_q + 1'b1;
              go_q   <= 1'b1;
            end else if (pass_last) begin
              not_found <= 1'b1;
              done      <= 1'b1;
              state     <= S_IDLE;
            end else begin
              addr_q   <= '0;
              pass_q   <= pass_q + 1'b1;
              tmr_go_q <= 1'b1;
              state    <= S_WAIT;
            end
          end else begin
            phy_id[31:16] <= rd_data;
            go_q          <= 1'b1;
            state         <= S_ID2;
          end
        end
        S_ID2: if (rd_done) begin
          phy_id[15:0] <= rd_data;
          phy_found    <= 1'b1;
          poll_q       <= '0;
          go_q         <= 1'b1;
          state        <= S_CTRL;
        end
        S_CTRL: if (rd_done) begin
          ctrl_reg <= rd_data;
          mask_q   <= link_mask(rd_data);
          go_q     <= 1'b1;
          state    <= S_STAT;
        end
        S_STAT: if (rd_done) begin
          status_reg <= rd_data;
          if (link_ok) begin
            link_up <= 1'b1;
            done    <= 1'b1;
            state   <= S_IDLE;
          end else if (poll_last) begin
            link_timeout <= 1'b1;
            done         <= 1'b1;
            state        <= S_IDLE;
          end else begin
            poll_q <= poll_q + 1'b1;
            go_q   <= 1'b1;
            state  <= S_CTRL;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/phy_link_seq_chk.sv
module phy_link_seq_chk
  import phy_seq_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        phy_found,
  input logic        not_found,
  input logic        link_up,
  input logic        link_timeout,
  input logic [4:0]  phy_addr,
  input logic [31:0] phy_id,
  input logic [15:0] ctrl_reg,
  input logic [15:0] status_reg,
  input logic        mdio_req,
  input logic [4:0]  mdio_phy,
  input logic [4:0]  mdio_reg,
  input logic        mdio_rsp_valid,
  input logic        waiting
);

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_req && !mdio_rsp_valid |=> mdio_req && $stable(mdio_phy) && $stable(mdio_reg));

  p_req_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_req && mdio_rsp_valid |=> !mdio_req);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_req);

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $countones({link_up, link_timeout, not_found}) == 1);

  p_wait_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> !mdio_req);

  p_notfound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    not_found |-> !phy_found && !link_up);

  p_link_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    link_up |-> status_reg[LINK_OK_BIT]);

  p_an_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    link_up && ctrl_reg[AN_ENABLE_BIT] |-> status_reg[AN_DONE_BIT]);

  p_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(phy_id) && $stable(phy_addr) && $stable(ctrl_reg)
      && $stable(status_reg) && $stable(link_up) && $stable(link_timeout)
      && $stable(not_found) && $stable(phy_found));

endmodule

bind phy_link_seq phy_link_seq_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .start          (start),
  .busy           (busy),
  .done           (done),
  .phy_found      (phy_found),
  .not_found      (not_found),
  .link_up        (link_up),
  .link_timeout   (link_timeout),
  .phy_addr       (phy_addr),
  .phy_id         (phy_id),
  .ctrl_reg       (ctrl_reg),
  .status_reg     (status_reg),
  .mdio_req       (mdio_req),
  .mdio_phy       (mdio_phy),
  .mdio_reg       (mdio_reg),
  .mdio_rsp_valid (mdio_rsp_valid),
  .waiting        (waiting)
);

// File: tb/tb_phy_link_seq.sv
`timescale 1ns/1ps
module tb_phy_link_seq;
  localparam int PASSES = 11;
  localparam int WAIT   = 20;
  localparam int POLLS  = 5;
  localparam int LAT    = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, done, phy_found, not_found, link_up, link_timeout;
  logic [4:0] phy_addr, mdio_phy, mdio_reg;
  logic [31:0] phy_id;
  logic [15:0] ctrl_reg, status_reg, mdio_rdata;
  logic mdio_req, mdio_rsp_valid;

  always #2 clk = ~clk;

  phy_link_seq #(.PASSES(PASSES), .WAIT_CYCLES(WAIT), .MAX_POLLS(POLLS)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .phy_found(phy_found), .not_found(not_found), .link_up(link_up),
    .link_timeout(link_timeout), .phy_addr(phy_addr), .phy_id(phy_id),
    .ctrl_reg(ctrl_reg), .status_reg(status_reg), .mdio_req(mdio_req),
    .mdio_phy(mdio_phy), .mdio_reg(mdio_reg), .mdio_rsp_valid(mdio_rsp_valid),
    .mdio_rdata(mdio_rdata)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // PHY population model
  bit present [32];
  int wake_after, good_after;
  logic [15:0] ctrl_val, stat_good, stat_bad;
  int id1_reads, ctrl_reads, stat_reads, order_err, waits_seen, glitches, done_cnt;
  int last_addr, cyc, last_cyc;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (done) done_cnt++;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < 32; i++) present[i] = 1'b0;
    wake_after = 0; good_after = 0;
    ctrl_val = 16'h0; stat_good = 16'h0; stat_bad = 16'h0;
    id1_reads = 0; ctrl_reads = 0; stat_reads = 0; order_err = 0;
    waits_seen = 0; glitches = 0; done_cnt = 0; last_addr = 31;
  endtask

  task automatic respond(input logic [4:0] a, input logic [4:0] r);
    case (r)
      5'd2: begin
        if (a != ((last_addr == 31) ? 0 : last_addr + 1)) order_err++;
        if (a == 0 && id1_reads > 0 && (cyc - last_cyc) >= WAIT) waits_seen++;
        last_addr = a;
        mdio_rdata = (present[a] && id1_reads >= wake_after) ? (16'h0100 | {11'h0, a}) : 16'hFFFF;
        id1_reads++;
      end
      5'd3: mdio_rdata = 16'hA000 | {11'h0, a};
      5'd0: begin mdio_rdata = ctrl_val; ctrl_reads++; end
      5'd1: begin mdio_rdata = (stat_reads >= good_after) ? stat_good : stat_bad; stat_reads++; end
      default: mdio_rdata = 16'hDEAD;
    endcase
  endtask

  // Management-bus responder
  initial begin
    mdio_rsp_valid = 1'b0;
    mdio_rdata = '0;
    forever begin
      @(negedge clk);
      if (mdio_req) begin
        for (int k = 0; k < LAT; k++) begin
          @(negedge clk);
          if (!mdio_req) glitches++;
        end
        respond(mdio_phy, mdio_reg);
        mdio_rsp_valid = 1'b1;
        @(negedge clk);
        mdio_rsp_valid = 1'b0;
        last_cyc = cyc;
      end
    end
  end

  task automatic run_seq(input bit extra_start);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R8", "busy after start", busy, 1'b1);
    for (int i = 0; i < 20000; i++) begin
      if (done) break;
      start = (extra_start && i == 10);
      @(negedge clk);
    end
    start = 1'b0;
    chk("R8", "busy low at done", busy, 1'b0);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R11", "busy", busy, 0);
    chk("R11", "done", done, 0);
    chk("R11", "mdio_req", mdio_req, 0);
    chk("R11", "flags", {phy_found, not_found, link_up, link_timeout}, 4'b0000);
  endtask

  task automatic t_two_phys_an();
    clear_model();
    present[5] = 1; present[9] = 1;
    ctrl_val = 16'h1000; stat_bad = 16'h0004; stat_good = 16'h0024; good_after = 2;
    run_seq(1'b1);
    chk("R1", "id1 reads (stop at first, start ignored R9)", id1_reads, 6);
    chk("R1", "scan order errors", order_err, 0);
    chk("R2", "phy_addr", phy_addr, 5);
    chk("R2", "phy_id", phy_id, 32'h0105A005);
    chk("R2", "phy_found", phy_found, 1);
    chk("R5", "status reads with AN", stat_reads, 3);
    chk("R7", "ctrl reads per iteration", ctrl_reads, 3);
    chk("R5", "link_up", link_up, 1);
    chk("R5", "status_reg", status_reg, 16'h0024);
    chk("R8", "single done", done_cnt, 1);
    chk("R10", "request dropped early", glitches, 0);
    repeat (30) @(negedge clk);
    chk("R9", "phy_id held", phy_id, 32'h0105A005);
    chk("R9", "ctrl_reg held", ctrl_reg, 16'h1000);
    chk("R9", "no further done", done_cnt, 1);
  endtask

  task automatic t_last_addr_fixed();
    clear_model();
    present[31] = 1;
    ctrl_val = 16'h0000; stat_bad = 16'h0020; stat_good = 16'h0004; good_after = 1;
    run_seq(1'b0);
    chk("R1", "id1 reads to addr 31", id1_reads, 32);
    chk("R2", "phy_addr 31", phy_addr, 31);
    chk("R6", "status reads fixed mode", stat_reads, 2);
    chk("R6", "link_up", link_up, 1);
    chk("R6", "link_timeout", link_timeout, 0);
  endtask

  task automatic t_none();
    clear_model();
    run_seq(1'b0);
    chk("R4", "not_found", not_found, 1);
    chk("R4", "phy_found", phy_found, 0);
    chk("R4", "phy_addr", phy_addr, 31);
    chk("R3", "id1 reads all passes", id1_reads, PASSES * 32);
    chk("R3", "waits between passes", waits_seen, PASSES - 1);
    chk("R4", "no ctrl/status reads", ctrl_reads + stat_reads, 0);
    chk("R1", "order errors", order_err, 0);
    chk("R8", "single done", done_cnt, 1);
  endtask

  task automatic t_late_wake();
    clear_model();
    present[10] = 1; wake_after = 70;
    ctrl_val = 16'h1000; stat_good = 16'h0024; good_after = 0;
    run_seq(1'b0);
    chk("R3", "id1 reads until wake", id1_reads, 75);
    chk("R3", "waits before third pass", waits_seen, 2);
    chk("R2", "phy_addr", phy_addr, 10);
    chk("R5", "link_up", link_up, 1);
  endtask

  task automatic t_timeout();
    clear_model();
    present[0] = 1;
    ctrl_val = 16'h1000; stat_bad = 16'h0004; stat_good = 16'h0024; good_after = 1000;
    run_seq(1'b0);
    chk("R7", "status reads", stat_reads, POLLS);
    chk("R7", "ctrl reads", ctrl_reads, POLLS);
    chk("R7", "link_timeout", link_timeout, 1);
    chk("R7", "link_up", link_up, 0);
    chk("R2", "phy_addr 0", phy_addr, 0);
  endtask

  initial begin
    #(4 * 190000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    clear_model();
    cyc = 0; last_cyc = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_two_phys_an();
    t_last_addr_fixed();
    t_none();
    t_late_wake();
    t_timeout();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule